// File: doc/BRIEF.md
# Boot ROM overlay address decoder

This block turns a 24-bit processor address into a one-hot set of chip selects for the main RAM, the boot ROM, the map RAM, the video RAM, the general status register, the two bus status registers, the expansion card window and the general control register. Other peripheral slots are not served here. An access to one of them raises no select. It returns an all-ones fill word on reads and sets a sticky flag that a testbench can watch.

After reset a boot overlay is active. While the overlay is active, address bit 23 is forced high before decoding. Every access, including the reset vector fetch at address zero, therefore lands in ROM. Software turns the overlay off by writing a one to the overlay-release bit of the general control register. From then on low addresses reach RAM and the I/O zone. The decoder is purely combinational apart from the release flag and the sticky flag. Selects, the effective address and the fill word are valid in the same cycle as the strobe.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After a synchronous reset, `ram_visible` is 0 and `unh_seen` is 0.
- R2: While `ram_visible` is 0, `eff_addr` equals `acc_addr` with bit 23 set. While it is 1, `eff_addr` equals `acc_addr`. All decoding below uses `eff_addr`.
- R3: An effective address in 0x000000–0x3FFFFF asserts `cs_vec[0]` (RAM).
- R4: An effective address in 0x800000–0xBFFFFF asserts `cs_vec[1]` (ROM) on a read. A write there asserts no select, gives a zero fill word and does not set `unh_seen`.
- R5: In 0x400000–0x7FFFFF, bits 19:16 choose a 64 KB slot: 0 gives `cs_vec[2]` (map RAM), 1 gives `cs_vec[4]` (general status), 2 gives `cs_vec[3]` (video RAM, mirrored through the slot), 3 gives `cs_vec[5]` (bus status 0) and 4 gives `cs_vec[6]` (bus status 1). Slots 5 to 15 are unhandled.
- R6: An effective address in 0xC00000–0xDFFFFF asserts `cs_vec[7]` (expansion), and `exp_slot` equals address bits 20:18, which selects one of eight 256 KB slots. `exp_slot` is 0 for any other access.
- R7: A write whose effective address has bits 23:21 = 111, bits 18:16 = 100 and bits 14:12 = 011 asserts `cs_vec[8]` (general control). With `acc_lanes` = 11 (word) it loads `ram_visible` from `acc_wdata[15]`. With `acc_lanes` = 10 (even byte, data right-justified) it loads from `acc_wdata[7]`. With `acc_lanes` = 01 (odd byte) it leaves the flag unchanged. The new value is visible after the clock edge. No other access changes the flag.
- R8: A read from an unhandled address (including a read of the general control address) drives `fill_data` to all ones. In every other case `fill_data` is zero.
- R9: Any strobed access to an unhandled address, read or write, sets `unh_seen`. It stays set until reset.
- R10: At most one bit of `cs_vec` is set, and none while `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_lanes | input | 2 | Byte lanes: bit 1 even byte, bit 0 odd byte |
| acc_addr | input | 24 | Processor byte address |
| acc_wdata | input | 16 | Write data; single bytes in bits 7:0 |
| eff_addr | output | 24 | Address after the overlay is applied |
| cs_vec | output | 9 | One-hot region selects |
| exp_slot | output | 3 | Expansion slot index |
| fill_data | output | 16 | All ones on an unhandled read, else zero |
| ram_visible | output | 1 | Overlay released (1 = normal map) |
| unh_seen | output | 1 | Sticky unhandled-access flag |

## Verification
The hardest states to reach from the ports are those behind the overlay. Until a control write with the release bit set has landed, no address can reach RAM or the I/O slots, because each of them is redirected to ROM or the expansion window. The stimulus therefore opens with directed release and re-arm writes through all three lane patterns. The random phase aims a share of its writes at the control address, mixed with the other regions, so the run keeps crossing between the overlaid map and the normal map. It also checks that an I/O address reappears as an expansion slot while the overlay is active.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
    localparam int ADDR_W  = 24;
    localparam int N_SEL   = 9;
    localparam int SLOT_W  = 3;
    localparam int LANES_W = 2;

    // region codes: values 0..N_SEL-1 match the select bit positions
    typedef enum logic [3:0] {
        RG_RAM   = 4'd0,
        RG_ROM   = 4'd1,
        RG_MAP   = 4'd2,
        RG_VID   = 4'd3,
        RG_GSTAT = 4'd4,
        RG_BST0  = 4'd5,
        RG_BST1  = 4'd6,
        RG_EXP   = 4'd7,
        RG_CTRL  = 4'd8,
        RG_NONE  = 4'd9,
        RG_ROMWR = 4'd10
    } region_e;

    typedef struct packed {
        region_e           rg;
        logic [SLOT_W-1:0] slot;
    } decode_t;

    // control register page: bits 18:16 and 14:12
    localparam logic [2:0] CTRL_HI = 3'd4;
    localparam logic [2:0] CTRL_LO = 3'd3;

    function automatic logic [ADDR_W-1:0] apply_overlay(
        input logic [ADDR_W-1:0] a, input logic visible);
        logic [ADDR_W-1:0] top_bit;
        top_bit = {1'b1, {(ADDR_W-1){1'b0}}};
        return visible ? a : (a | top_bit);
    endfunction
endpackage

// File: rtl/ovl_addr_fix.sv
module ovl_addr_fix
    import boot_overlay_pkg::*;
(
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              visible,
    output logic [ADDR_W-1:0] eff
);
    assign eff = apply_overlay(raw_addr, visible);
endmodule

// File: rtl/ovl_region_dec.sv
module ovl_region_dec
    import boot_overlay_pkg::*;
(
    input  logic              is_write,
    input  logic [ADDR_W-1:0] eff,
    output decode_t           dec
);
    logic unused_bits;
    assign unused_bits = ^{eff[15], eff[11:0]};

    always_comb begin
        dec.rg   = RG_NONE;
        dec.slot = '0;
        unique case (eff[23:22])
            2'b00: dec.rg = RG_RAM;
            2'b01: begin
                case (eff[19:16])
                    4'd0:    dec.rg = RG_MAP;
                    4'd1:    dec.rg = RG_GSTAT;
                    4'd2:    dec.rg = RG_VID;
                    4'd3:    dec.rg = RG_BST0;
                    4'd4:    dec.rg = RG_BST1;
                    default: dec.rg = RG_NONE;
                endcase
            end
            2'b10: dec.rg = is_write ? RG_ROMWR : RG_ROM;
            2'b11: begin
                if (!eff[21]) begin
                    dec.rg   = RG_EXP;
                    dec.slot = eff[20:18];
                end else if (is_write && eff[18:16] == CTRL_HI
                             && eff[14:12] == CTRL_LO) begin
                    dec.rg = RG_CTRL;
                end else begin
                    dec.rg = RG_NONE;
                end
            end
            default: dec.rg = RG_NONE;
        endcase
    end
endmodule

// File: rtl/ovl_flag_reg.sv
module ovl_flag_reg
    import boot_overlay_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LANES_W-1:0] lanes,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               unh_hit,
    output logic               visible,
    output logic               sticky
);
    localparam int WORD_BIT = DATA_W - 1;
    localparam int BYTE_BIT = 7;

    logic unused_data;
    assign unused_data = ^{wdata[WORD_BIT-1:BYTE_BIT+1], wdata[BYTE_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            visible <= 1'b0;
            sticky  <= 1'b0;
        end else begin
            if (load) begin
                if (lanes == 2'b11)
                    visible <= wdata[WORD_BIT];
                else if (lanes == 2'b10)
                    visible <= wdata[BYTE_BIT];
            end
            if (unh_hit)
                sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import boot_overlay_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [LANES_W-1:0] acc_lanes,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [N_SEL-1:0]   cs_vec,
    output logic [SLOT_W-1:0]  exp_slot,
    output logic [DATA_W-1:0]  fill_data,
    output logic               ram_visible,
    output logic               unh_seen
);
    decode_t dec;
    logic    ctrl_load;
    logic    unh_hit;

    ovl_addr_fix u_fix (
        .raw_addr (acc_addr),
        .visible  (ram_visible),
        .eff      (eff_addr)
    );

    ovl_region_dec u_dec (
        .is_write (acc_write),
        .eff      (eff_addr),
        .dec      (dec)
    );

    for (genvar i = 0; i < N_SEL; i++) begin : g_cs
        assign cs_vec[i] = acc_valid && (dec.rg == region_e'(i));
    end

    assign exp_slot  = (acc_valid && dec.rg == RG_EXP) ? dec.slot : '0;
    assign unh_hit   = acc_valid && (dec.rg == RG_NONE);
    assign fill_data = (unh_hit && !acc_write) ? '1 : '0;
    assign ctrl_load = acc_valid && acc_write && (dec.rg == RG_CTRL);

    ovl_flag_reg #(.DATA_W(DATA_W)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .load    (ctrl_load),
        .lanes   (acc_lanes),
        .wdata   (acc_wdata),
        .unh_hit (unh_hit),
        .visible (ram_visible),
        .sticky  (unh_seen)
    );
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk
    import boot_overlay_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [N_SEL-1:0]  cs_vec,
    input logic [DATA_W-1:0] fill_data,
    input logic              ram_visible,
    input logic              unh_seen
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_vec)); // R10
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> cs_vec == '0); // R10
    AST_BOOT_ROM: assert property (@(posedge clk) disable iff (rst)
        !ram_visible |-> eff_addr[ADDR_W-1]); // R2
    AST_RAM_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_vec[0] |-> eff_addr[23:22] == 2'b00); // R3
    AST_ROM_WR_DROP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && eff_addr[23:22] == 2'b10)
        |-> (cs_vec == '0 && fill_data == '0)); // R4
    AST_FILL_READ: assert property (@(posedge clk) disable iff (rst)
        (fill_data != '0) |-> (acc_valid && !acc_write && cs_vec == '0)); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        unh_seen |=> unh_seen); // R9
    AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && cs_vec[8]) |=> $stable(ram_visible)); // R7
endmodule

bind boot_overlay_decoder boot_overlay_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .eff_addr    (eff_addr),
    .cs_vec      (cs_vec),
    .fill_data   (fill_data),
    .ram_visible (ram_visible),
    .unh_seen    (unh_seen)
);

// File: tb/sim_boot_overlay_decoder.sv
`timescale 1ns/1ps
module sim_boot_overlay_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_lanes = 2'b11;
    logic [23:0] acc_addr  = '0;
    logic [15:0] acc_wdata = '0;
    logic [23:0] eff_addr;
    logic [8:0]  cs_vec;
    logic [2:0]  exp_slot;
    logic [15:0] fill_data;
    logic        ram_visible;
    logic        unh_seen;

    int n_vec  = 0;
    int n_fail = 0;
    bit m_vis  = 1'b0;
    bit m_stk  = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    boot_overlay_decoder u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_lanes(acc_lanes), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .eff_addr(eff_addr), .cs_vec(cs_vec), .exp_slot(exp_slot),
        .fill_data(fill_data), .ram_visible(ram_visible), .unh_seen(unh_seen)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h addr=%h", req, act, expv, acc_addr);
        end
    endtask

    // reference model, written from the requirement list
    task automatic ref_decode(input logic [23:0] a, input bit v, input bit wr, input bit vis,
                              output logic [23:0] e, output logic [8:0] cs,
                              output logic [2:0] sl, output logic [15:0] fl,
                              output bit unh, output bit ld);
        int s;
        e = vis ? a : (a | 24'h800000);
        cs = '0; sl = '0; fl = '0; unh = 0; ld = 0;
        if (e < 24'h400000) cs = 9'd1 << 0;
        else if (e < 24'h800000) begin
            s = int'((e - 24'h400000) >> 16) & 15;
            case (s)
                0: cs = 9'd1 << 2;
                1: cs = 9'd1 << 4;
                2: cs = 9'd1 << 3;
                3: cs = 9'd1 << 5;
                4: cs = 9'd1 << 6;
                default: unh = 1;
            endcase
        end else if (e < 24'hC00000) begin
            if (!wr) cs = 9'd1 << 1;
        end else if (e < 24'hE00000) begin
            cs = 9'd1 << 7;
            sl = 3'((e - 24'hC00000) >> 18);
        end else if (wr && ((e & 24'h077000) == 24'h043000)) begin
            cs = 9'd1 << 8; ld = 1;
        end else unh = 1;
        if (!v) begin cs = '0; sl = '0; unh = 0; ld = 0; end
        if (unh && !wr) fl = 16'hFFFF;
    endtask

    // one access: drive at negedge, check outputs, clock it, update model
    task automatic access(input bit v, input bit wr, input logic [1:0] ln,
                          input logic [23:0] a, input logic [15:0] wd);
        logic [23:0] e; logic [8:0] cs; logic [2:0] sl; logic [15:0] fl;
        bit unh, ld;
        @(negedge clk);
        check("R1/R7 flag", 32'(ram_visible), 32'(m_vis));
        check("R9 sticky", 32'(unh_seen), 32'(m_stk));
        acc_valid = v; acc_write = wr; acc_lanes = ln; acc_addr = a; acc_wdata = wd;
        #1;
        ref_decode(a, v, wr, m_vis, e, cs, sl, fl, unh, ld);
        check("R2 eff_addr", 32'(eff_addr), 32'(e));
        check("R3-R7 cs_vec", 32'(cs_vec), 32'(cs));
        check("R6 exp_slot", 32'(exp_slot), 32'(sl));
        check("R8 fill_data", 32'(fill_data), 32'(fl));
        @(posedge clk);
        if (ld) begin
            if (ln == 2'b11) m_vis = wd[15];
            else if (ln == 2'b10) m_vis = wd[7];
        end
        if (unh) m_stk = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; acc_valid = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_vis = 0; m_stk = 0;
        check("R1 reset flag", 32'(ram_visible), 32'd0);
        check("R1 reset sticky", 32'(unh_seen), 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R2: overlay active, low address lands in ROM
        access(1, 0, 2'b11, 24'h001234, 16'h0);
        // R2/R6: I/O address becomes expansion slot while overlaid
        access(1, 0, 2'b11, 24'h400000, 16'h0);
        // R7: odd byte write must not release
        access(1, 1, 2'b01, 24'hE43001, 16'h00FF);
        // R7: word write releases
        access(1, 1, 2'b11, 24'hE43000, 16'h8000);
        // R3 RAM, R5 slots
        access(1, 0, 2'b11, 24'h001234, 16'h0);
        access(1, 1, 2'b11, 24'h3FFFFE, 16'h1);
        access(1, 0, 2'b11, 24'h4007FE, 16'h0);
        access(1, 0, 2'b11, 24'h410000, 16'h0);
        access(1, 1, 2'b11, 24'h42FFFE, 16'h0);
        access(1, 0, 2'b11, 24'h430000, 16'h0);
        access(1, 0, 2'b11, 24'h44FFFF, 16'h0);
        // R4 ROM write dropped, ROM read
        access(1, 1, 2'b11, 24'h800010, 16'hAAAA);
        access(1, 0, 2'b11, 24'hBFFFFE, 16'h0);
        // R6 last expansion slot
        access(1, 0, 2'b11, 24'hDC0000, 16'h0);
        // R8/R9 unhandled read
        access(1, 0, 2'b11, 24'h450000, 16'h0);
        // R8 control address read is unhandled
        access(1, 0, 2'b11, 24'hF43000, 16'h0);
        // R7 even byte write re-arms overlay from bit 7
        access(1, 1, 2'b10, 24'hF43000, 16'h0000);
        access(1, 0, 2'b11, 24'h000000, 16'h0);
        access(1, 1, 2'b10, 24'hE43000, 16'h0080);
        // R10 idle cycle
        access(0, 1, 2'b11, 24'hE43000, 16'h0000);
        // R1 reset mid-run
        do_reset();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] a;
            logic [1:0]  ln;
            int pick;
            bit v, wr;
            a    = 24'($urandom);
            pick = int'($urandom_range(0, 9));
            if (pick < 2) a = {3'b111, a[20:19], 3'b100, a[15], 3'b011, a[11:0]};
            else if (pick < 4) a = {2'b01, a[21:20], 4'($urandom_range(0, 6)), a[15:0]};
            case ($urandom_range(0, 2))
                0: ln = 2'b01;
                1: ln = 2'b10;
                default: ln = 2'b11;
            endcase
            v  = ($urandom_range(0, 9) != 0);
            wr = $urandom_range(0, 1) == 1;
            access(v, wr, ln, a, 16'($urandom));
        end
        @(negedge clk);
        check("R7 final flag", 32'(ram_visible), 32'(m_vis));
        check("R9 final sticky", 32'(unh_seen), 32'(m_stk));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule